// File: doc/BRIEF.md
# Programmable LCD Segment Allocation Selector

This block produces the segment drive levels of a multiplexed LCD controller. It holds a bank of 72 byte-wide display registers and two pointer tables. There is one pointer entry for every segment/common pair: 50 segments times 8 commons. For each pair, one table gives a display-register number and the other gives a bit position. During a common's time slot, each segment output carries the bit that its pointer pair selects. Any pixel can therefore be taken from any bit of any display register.

A slot counter steps through the active commons on each frame-slot tick. The 50 segment outputs are registered and are reloaded on that same tick with the pixels of the new slot.

Pointer lookup is used only when three things hold: the allocation enable is set, the map-type input selects type 3, and the number of active commons is within the limit for the selected frame rate. In every other case a fixed wiring applies: segment m in common n shows bit n of display register m. A simple write port loads all three stores, and a combinational read port returns their contents.

Top module: `lcd_seg_alloc`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `seg_out` and `com_idx` are 0 and every readable location returns 0. With all stores cleared, a tick in any mode leaves `seg_out` at 0.
- R2: With `wr_en` high, the next clock edge writes `wr_data` to the selected store. The store is chosen by `wr_sel`: 0 is the display registers (address 0 to 71, 8 bits), 1 is the register-pointer table, and 2 is the bit-pointer table (low 3 bits kept). Both tables use address `com*50 + seg`, range 0 to 399. `rd_sel`/`rd_addr` with the same codes return the stored value, zero-extended, in the same cycle. Writes beyond a store's range are dropped. Reads beyond a store's range, or with select 3, return 0.
- R3: On each cycle with `slot_tick` high, `com_idx` becomes 0 if it is greater than or equal to `duty_sel`, and otherwise advances by 1. The number of active commons is `duty_sel`+1, in the range 1 to 16.
- R4: `seg_out` changes only on clock edges where `slot_tick` is high. It then shows the pixels of the common that `com_idx` takes at that same edge.
- R5: When lookup is not in effect, segment m during common n shows bit n of display register m for n < 8. For n of 8 or more it shows 0.
- R6: Lookup is in effect only when `alloc_en` = 1, `map_sel` = 3, and `duty_sel`+1 does not exceed the limit for `rate_sel`. The limits are 8 for codes 0 and 1 (slowest rates), 7 for code 2, and 6 for code 3.
- R7: When lookup is in effect, segment m during common n shows bit `B` of display register `A`. Here `A` and `B` are the register-pointer and bit-pointer entries at address n*50+m.
- R8: A register pointer of 72 or more makes that pixel 0.
- R9: A write made before a tick is reflected in the segments loaded on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target store: 0 display, 1 register pointer, 2 bit pointer |
| wr_addr | input | 9 | Write location |
| wr_data | input | 8 | Write value |
| rd_sel | input | 2 | Read store select, same codes as wr_sel |
| rd_addr | input | 9 | Read location |
| rd_data | output | 8 | Read value, combinational |
| alloc_en | input | 1 | Allocation enable |
| map_sel | input | 2 | Map type; 3 permits lookup |
| duty_sel | input | 4 | Active commons minus one |
| rate_sel | input | 2 | Frame-rate code, 0 slowest to 3 fastest |
| slot_tick | input | 1 | Frame-slot advance pulse |
| com_idx | output | 4 | Current common slot |
| seg_out | output | 50 | Segment levels for the current slot |

## Verification
A corrupted pointer entry or display byte shows up on exactly one segment, and only in one common slot, so each full frame of slots has to be compared segment by segment. A wrong enable decision flips a whole slot between the fixed and the looked-up pattern at the next tick. For that reason every frame-rate/duty boundary is tested on both sides. A slot counter that wraps at the wrong point becomes visible on `com_idx` within one frame, and the segment pattern then follows the wrong common.

// File: rtl/lcd_seg_alloc_pkg.sv
package lcd_seg_alloc_pkg;

    localparam logic [1:0] SEL_DISP = 2'd0;
    localparam logic [1:0] SEL_RPTR = 2'd1;
    localparam logic [1:0] SEL_BPTR = 2'd2;

    localparam logic [1:0] MAP_LOOKUP = 2'd3;

    // highest number of active commons that still permits pointer lookup
    function automatic int lookup_com_limit(input logic [1:0] rate);
        case (rate)
            2'd0, 2'd1: return 8;
            2'd2:       return 7;
            default:    return 6;
        endcase
    endfunction

endpackage

// File: rtl/lcd_seg_alloc_store.sv
module lcd_seg_alloc_store
    import lcd_seg_alloc_pkg::*;
#(
    parameter int NSEG = 50,
    parameter int NPC  = 8,
    parameter int NREG = 72,
    parameter int DW   = 8,
    parameter int AW   = 8,
    localparam int NENT = NSEG * NPC,
    localparam int IW   = $clog2(NENT > NREG ? NENT : NREG),
    localparam int BW   = $clog2(DW),
    localparam int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [IW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_sel,
    input  logic [IW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] disp  [NREG],
    output logic [AW-1:0] rptr  [NENT],
    output logic [BW-1:0] bptr  [NENT]
);

    typedef struct {
        logic [DW-1:0] disp [NREG];
        logic [AW-1:0] rptr [NENT];
        logic [BW-1:0] bptr [NENT];
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            for (int i = 0; i < NREG; i++) st_d.disp[i] = '0;
            for (int i = 0; i < NENT; i++) begin
                st_d.rptr[i] = '0;
                st_d.bptr[i] = '0;
            end
        end else if (wr_en) begin
            case (wr_sel)
                SEL_DISP: if (int'(wr_addr) < NREG)
                    st_d.disp[wr_addr[RW-1:0]] = wr_data;
                SEL_RPTR: if (int'(wr_addr) < NENT)
                    st_d.rptr[wr_addr] = wr_data[AW-1:0];
                SEL_BPTR: if (int'(wr_addr) < NENT)
                    st_d.bptr[wr_addr] = wr_data[BW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_DISP: if (int'(rd_addr) < NREG) rd_data = st_q.disp[rd_addr[RW-1:0]];
            SEL_RPTR: if (int'(rd_addr) < NENT) rd_data = DW'(st_q.rptr[rd_addr]);
            SEL_BPTR: if (int'(rd_addr) < NENT) rd_data = DW'(st_q.bptr[rd_addr]);
            default:  rd_data = '0;
        endcase
    end

    assign disp = st_q.disp;
    assign rptr = st_q.rptr;
    assign bptr = st_q.bptr;

    // R2: an in-range display write is visible on the read port after the edge
    assert_disp_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_DISP && int'(wr_addr) < NREG
         && rd_sel == SEL_DISP && rd_addr == wr_addr)
        |=> (rd_sel != SEL_DISP || rd_addr != $past(rd_addr) || rd_data == $past(wr_data)));

endmodule

// File: rtl/lcd_seg_alloc_gate.sv
module lcd_seg_alloc_gate
    import lcd_seg_alloc_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_en,
    input  logic [1:0]    map_sel,
    input  logic [CW-1:0] duty_sel,
    input  logic [1:0]    rate_sel,
    output logic          lookup_on
);

    logic duty_fits;

    always_comb begin
        duty_fits = (int'(duty_sel) + 1) <= lookup_com_limit(rate_sel);
        lookup_on = alloc_en && (map_sel == MAP_LOOKUP) && duty_fits;
    end

    // R6: lookup never in effect with more than eight commons
    assert_no_lookup_wide_duty_R6: assert property (@(posedge clk) disable iff (rst)
        lookup_on |-> (int'(duty_sel) < 8));

    // R6: lookup needs the map type and the enable
    assert_lookup_needs_mode_R6: assert property (@(posedge clk) disable iff (rst)
        lookup_on |-> (alloc_en && map_sel == 2'd3));

endmodule

// File: rtl/lcd_seg_alloc_slot.sv
module lcd_seg_alloc_slot #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_tick,
    input  logic [CW-1:0] duty_sel,
    output logic [CW-1:0] com_q,
    output logic [CW-1:0] com_nx
);

    typedef struct packed {
        logic [CW-1:0] com;
    } slot_t;

    slot_t sl_d, sl_q;

    always_comb begin
        com_nx = (sl_q.com >= duty_sel) ? '0 : sl_q.com + 1'b1;
        sl_d   = sl_q;
        if (rst)
            sl_d.com = '0;
        else if (slot_tick)
            sl_d.com = com_nx;
    end

    always_ff @(posedge clk) begin
        sl_q <= sl_d;
    end

    assign com_q = sl_q.com;

    // R3: after a tick the slot never exceeds the duty setting
    assert_com_in_duty_R3: assert property (@(posedge clk) disable iff (rst)
        slot_tick |=> (com_q <= $past(duty_sel)));

    // R3: without a tick the slot holds
    assert_com_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !slot_tick |=> $stable(com_q));

endmodule

// File: rtl/lcd_seg_alloc_pixel.sv
module lcd_seg_alloc_pixel #(
    parameter int NSEG = 50,
    parameter int NPC  = 8,
    parameter int NREG = 72,
    parameter int DW   = 8,
    parameter int AW   = 8,
    parameter int CW   = 4,
    localparam int NENT = NSEG * NPC,
    localparam int IW   = $clog2(NENT > NREG ? NENT : NREG),
    localparam int BW   = $clog2(DW),
    localparam int RW   = $clog2(NREG),
    localparam int PCW  = $clog2(NPC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            slot_tick,
    input  logic            lookup_on,
    input  logic [CW-1:0]   com_nx,
    input  logic [DW-1:0]   disp [NREG],
    input  logic [AW-1:0]   rptr [NENT],
    input  logic [BW-1:0]   bptr [NENT],
    output logic [NSEG-1:0] seg_q
);

    typedef struct packed {
        logic [NSEG-1:0] seg;
    } seg_t;

    seg_t sg_d, sg_q;
    logic [NSEG-1:0] pix;

    for (genvar m = 0; m < NSEG; m++) begin : g_seg
        logic [IW-1:0] ent;
        logic [AW-1:0] ra;
        logic [BW-1:0] rb;
        logic [RW-1:0] ri;
        logic          look_bit;
        logic          fix_bit;

        always_comb begin
            ent      = IW'(int'(com_nx[PCW-1:0]) * NSEG + m);
            ra       = rptr[ent];
            rb       = bptr[ent];
            ri       = ra[RW-1:0];
            look_bit = (int'(ra) < NREG) ? disp[ri][rb] : 1'b0;
        end

        if (m < NREG) begin : g_fix
            always_comb fix_bit = (int'(com_nx) < NPC) ? disp[m][com_nx[PCW-1:0]] : 1'b0;
        end else begin : g_nofix
            always_comb fix_bit = 1'b0;
        end

        assign pix[m] = lookup_on ? look_bit : fix_bit;
    end

    always_comb begin
        sg_d = sg_q;
        if (rst)
            sg_d.seg = '0;
        else if (slot_tick)
            sg_d.seg = pix;
    end

    always_ff @(posedge clk) begin
        sg_q <= sg_d;
    end

    assign seg_q = sg_q.seg;

    // R4: segment levels move only on a slot tick
    assert_seg_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !slot_tick |=> $stable(seg_q));

    // R5: fixed mapping blanks every segment for commons above seven
    assert_fixed_high_com_blank_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_tick && !lookup_on && int'(com_nx) >= NPC) |=> (seg_q == '0));

endmodule

// File: rtl/lcd_seg_alloc.sv
module lcd_seg_alloc
    import lcd_seg_alloc_pkg::*;
#(
    parameter int NSEG = 50,
    parameter int NPC  = 8,
    parameter int NCOM = 16,
    parameter int NREG = 72,
    parameter int DW   = 8,
    parameter int AW   = 8,
    localparam int NENT = NSEG * NPC,
    localparam int IW   = $clog2(NENT > NREG ? NENT : NREG),
    localparam int BW   = $clog2(DW),
    localparam int CW   = $clog2(NCOM)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [IW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [1:0]      rd_sel,
    input  logic [IW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            alloc_en,
    input  logic [1:0]      map_sel,
    input  logic [CW-1:0]   duty_sel,
    input  logic [1:0]      rate_sel,
    input  logic            slot_tick,
    output logic [CW-1:0]   com_idx,
    output logic [NSEG-1:0] seg_out
);

    logic [DW-1:0] disp [NREG];
    logic [AW-1:0] rptr [NENT];
    logic [BW-1:0] bptr [NENT];
    logic          lookup_on;
    logic [CW-1:0] com_nx;

    lcd_seg_alloc_store #(
        .NSEG(NSEG), .NPC(NPC), .NREG(NREG), .DW(DW), .AW(AW)
    ) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
        .disp(disp), .rptr(rptr), .bptr(bptr)
    );

    lcd_seg_alloc_gate #(.CW(CW)) u_gate (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_en), .map_sel(map_sel),
        .duty_sel(duty_sel), .rate_sel(rate_sel),
        .lookup_on(lookup_on)
    );

    lcd_seg_alloc_slot #(.CW(CW)) u_slot (
        .clk(clk), .rst(rst), .slot_tick(slot_tick), .duty_sel(duty_sel),
        .com_q(com_idx), .com_nx(com_nx)
    );

    lcd_seg_alloc_pixel #(
        .NSEG(NSEG), .NPC(NPC), .NREG(NREG), .DW(DW), .AW(AW), .CW(CW)
    ) u_pixel (
        .clk(clk), .rst(rst), .slot_tick(slot_tick), .lookup_on(lookup_on),
        .com_nx(com_nx), .disp(disp), .rptr(rptr), .bptr(bptr),
        .seg_q(seg_out)
    );

    // R1: outputs held at zero through reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (seg_out == '0 && com_idx == '0));

endmodule

// File: tb/tb_lcd_seg_alloc.sv
module tb_lcd_seg_alloc;

    localparam int NSEG = 50;
    localparam int NREG = 72;
    localparam int NENT = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [8:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [8:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        alloc_en = 1'b0;
    logic [1:0]  map_sel = 2'd3;
    logic [3:0]  duty_sel = 4'd7;
    logic [1:0]  rate_sel = 2'd0;
    logic        slot_tick = 1'b0;
    logic [3:0]  com_idx;
    logic [NSEG-1:0] seg_out;

    int checks = 0;
    int failures = 0;
    int tcom = 0;
    int sh_disp [NREG];
    int sh_rp [NENT];
    int sh_bp [NENT];

    always #2 clk = ~clk;

    lcd_seg_alloc dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
        .alloc_en(alloc_en), .map_sel(map_sel), .duty_sel(duty_sel),
        .rate_sel(rate_sel), .slot_tick(slot_tick),
        .com_idx(com_idx), .seg_out(seg_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit lookup_expected();
        int lim;
        lim = (rate_sel < 2) ? 8 : (rate_sel == 2) ? 7 : 6;
        return alloc_en && map_sel == 2'd3 && (int'(duty_sel) + 1) <= lim;
    endfunction

    function automatic logic [NSEG-1:0] expect_segs(input int n, input bit look);
        logic [NSEG-1:0] v;
        for (int m = 0; m < NSEG; m++) begin
            if (look) begin
                int e = n * NSEG + m;
                v[m] = (sh_rp[e] >= NREG) ? 1'b0 : 1'(sh_disp[sh_rp[e]] >> sh_bp[e]);
            end else begin
                v[m] = (n < 8) ? 1'(sh_disp[m] >> n) : 1'b0;
            end
        end
        return v;
    endfunction

    task automatic wr(input logic [1:0] sel, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = 9'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 2'd0 && addr < NREG) sh_disp[addr] = data & 8'hFF;
        if (sel == 2'd1 && addr < NENT) sh_rp[addr] = data & 8'hFF;
        if (sel == 2'd2 && addr < NENT) sh_bp[addr] = data & 7;
    endtask

    task automatic rd(input logic [1:0] sel, input int addr, output int val);
        rd_sel = sel; rd_addr = 9'(addr);
        #1;
        val = int'(rd_data);
    endtask

    task automatic tick_check(input string req);
        bit look;
        look = lookup_expected();
        tcom = (tcom >= int'(duty_sel)) ? 0 : tcom + 1;
        @(negedge clk);
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
        chk({req, " com"}, 64'(com_idx), 64'(tcom));
        chk({req, " seg"}, 64'(seg_out), 64'(expect_segs(tcom, look)));
    endtask

    task automatic frame(input string req);
        for (int k = 0; k <= int'(duty_sel); k++) tick_check(req);
    endtask

    task automatic set_mode(input bit en, input int map, input int duty, input int rate);
        @(negedge clk);
        alloc_en = en; map_sel = 2'(map); duty_sel = 4'(duty); rate_sel = 2'(rate);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        for (int i = 0; i < NREG; i++) sh_disp[i] = 0;
        for (int i = 0; i < NENT; i++) begin sh_rp[i] = 0; sh_bp[i] = 0; end

        repeat (3) @(negedge clk);
        // R1: state held during reset
        chk("R1 seg in reset", 64'(seg_out), 64'd0);
        chk("R1 com in reset", 64'(com_idx), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 seg after reset", 64'(seg_out), 64'd0);
        for (int i = 0; i < NREG; i++) begin rd(2'd0, i, v); chk("R1 disp clear", 64'(v), 64'd0); end
        for (int i = 0; i < NENT; i += 7) begin
            rd(2'd1, i, v); chk("R1 rptr clear", 64'(v), 64'd0);
            rd(2'd2, i, v); chk("R1 bptr clear", 64'(v), 64'd0);
        end
        set_mode(1'b0, 3, 7, 0);
        tick_check("R1 cleared fixed");
        set_mode(1'b1, 3, 7, 0);
        tick_check("R1 cleared lookup");

        // R2: display register load and readback; R4: no tick, no change
        for (int i = 0; i < NREG; i++) wr(2'd0, i, (i * 37 + 11) & 8'hFF);
        chk("R4 seg stable without tick", 64'(seg_out), 64'd0);
        wr(2'd0, 72, 8'hFF);
        wr(2'd0, 300, 8'hFF);
        for (int i = 0; i < NREG; i++) begin rd(2'd0, i, v); chk("R2 disp readback", 64'(v), 64'(sh_disp[i])); end
        rd(2'd0, 72, v);  chk("R2 disp beyond range", 64'(v), 64'd0);
        rd(2'd3, 5, v);   chk("R2 select 3 reads zero", 64'(v), 64'd0);

        // R5: fixed mapping, eight commons then sixteen
        set_mode(1'b0, 3, 7, 0);
        frame("R5 fixed 8 com");
        set_mode(1'b1, 3, 15, 0);
        frame("R5 fixed 16 com");

        // R2: pointer tables
        for (int e = 0; e < NENT; e++) begin
            wr(2'd1, e, (e * 7 + 3) % 80);
            wr(2'd2, e, (e * 5 + 1) | 8'hF8);
        end
        wr(2'd1, 400, 8'h11);
        wr(2'd2, 511, 8'h07);
        for (int e = 0; e < NENT; e++) begin
            rd(2'd1, e, v); chk("R2 rptr readback", 64'(v), 64'(sh_rp[e]));
            rd(2'd2, e, v); chk("R2 bptr readback", 64'(v), 64'(sh_bp[e]));
        end
        rd(2'd1, 400, v); chk("R2 rptr beyond range", 64'(v), 64'd0);
        rd(2'd2, 511, v); chk("R2 bptr beyond range", 64'(v), 64'd0);

        // R7 R6: lookup and the enable boundaries
        set_mode(1'b1, 3, 7, 0); frame("R7 lookup rate0 duty8");
        set_mode(1'b1, 3, 7, 1); frame("R7 lookup rate1 duty8");
        set_mode(1'b1, 3, 7, 2); frame("R6 rate2 duty8 fixed");
        set_mode(1'b1, 3, 6, 2); frame("R6 rate2 duty7 lookup");
        set_mode(1'b1, 3, 6, 3); frame("R6 rate3 duty7 fixed");
        set_mode(1'b1, 3, 5, 3); frame("R6 rate3 duty6 lookup");
        set_mode(1'b1, 3, 8, 0); frame("R6 duty9 fixed");
        set_mode(1'b1, 2, 7, 0); frame("R6 map2 fixed");
        set_mode(1'b0, 3, 7, 0); frame("R6 enable off fixed");
        set_mode(1'b1, 3, 0, 0); frame("R7 lookup duty1");

        // R8: all display bits set, so only out-of-range pointers give zero
        for (int i = 0; i < NREG; i++) wr(2'd0, i, 8'hFF);
        set_mode(1'b1, 3, 7, 0);
        for (int k = 0; k < 8; k++) begin
            tick_check("R8 lookup");
            for (int m = 0; m < NSEG; m++)
                if (sh_rp[tcom * NSEG + m] >= NREG)
                    chk("R8 pointer beyond range blanks", 64'(seg_out[m]), 64'd0);
        end

        // R3: short duty wrap, then duty reduced below the current slot
        set_mode(1'b1, 3, 2, 0);
        for (int k = 0; k < 7; k++) tick_check("R3 wrap duty3");
        set_mode(1'b0, 3, 9, 0);
        while (tcom != 6) tick_check("R3 climb");
        set_mode(1'b0, 3, 2, 0);
        tick_check("R3 shrink wraps to zero");
        chk("R3 com zero after shrink", 64'(com_idx), 64'd0);

        // R9: a write just before a tick lands in that tick's segments
        set_mode(1'b1, 3, 7, 0);
        while (tcom != 0) tick_check("R9 align");
        wr(2'd0, 5, 8'h00);
        wr(2'd1, 1 * NSEG + 3, 5);
        wr(2'd2, 1 * NSEG + 3, 2);
        tick_check("R9 write before tick");
        chk("R9 seg3 now reads cleared register", 64'(seg_out[3]), 64'd0);
        wr(2'd0, 5, 8'h04);
        wr(2'd1, 2 * NSEG + 3, 5);
        wr(2'd2, 2 * NSEG + 3, 2);
        tick_check("R9 second write");
        chk("R9 seg3 now reads set bit", 64'(seg_out[3]), 64'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule